// File: doc/BRIEF.md
# Serial Port Individual Reset Controller

This block decides whether a serial audio port is running or parked, using nothing but the per-pin function-select register. While no pin is assigned to the serial function, the port sits in its individual reset state. In that state no frame is started, every status flag reads at its reset value and received-data reads return nothing valid. The control register keeps whatever software last wrote. Once any pin is switched to the serial function, the port goes active on the next clock edge. Shifting then begins at the first frame sync sampled after that point.

Software brings the port up in a fixed order. It first programs the control word while the port is parked, then preloads every enabled transmitter word, and last assigns a pin. At the edge where the port goes active, every enabled transmitter that was not preloaded is flagged as underrun. While the port is active, the configuration field of the control word is locked. A write that would change it is dropped and raises a sticky error. The enable fields stay writable at all times. The shift engine and the pad multiplexer sit outside this block: the block hands them the pin registers, the enables, the configuration and the transmit words, and it takes in a frame sync and received words.

Top module: `sp_ireset_ctrl`

## Requirements
- R1: After hardware reset (rst_n low), pin_sel and pin_dir are all zero, active and serial_run are low, cfg_err is low, and reads of the control word (address 2) and of the status word (address 3) return zero.
- R2: active equals the OR of pin_sel as it stood one clock earlier: a write to pin_sel (address 0) changes active at the edge after the write edge, and pin_dir (address 1) has no effect on it.
- R3: While active is low, the status bits rx_full (status bits [NUM_RX-1:0]) and underrun (status bits [NUM_RX+NUM_TX-1:NUM_RX]) read zero and serial_run is low. Entering individual reset leaves the control word unchanged.
- R4: A read (rd_en) returns rdata and rd_valid in the next cycle. A read of a received-data address (16 + channel) returns the captured word with rd_valid high while active, and clears that channel's rx_full. While active is low, the same read returns rdata zero with rd_valid low.
- R5: Control word layout is: tx enables at bits [NUM_TX-1:0], rx enables above them, two interrupt enables above those, and the configuration field cfg_mode at bits [CTRL_W-1:FREE_W]. The enable fields take every write. cfg_mode takes a write only while active is low.
- R6: cfg_err (also status bit NUM_RX+NUM_TX) is set by a control write while active whose cfg_mode value differs from the stored one. It stays set through individual reset and clears only on hardware reset.
- R7: serial_run rises at the first clock edge that samples fsync high while active is already high. It falls at the same edge as active.
- R8: Writes to a transmit address (8 + channel) store the word on tx_data and set that channel's preload mark (readable at address 4). The marks clear when the port enters individual reset. At the activation edge, underrun[i] becomes tx_en[i] AND NOT mark[i].
- R9: An rx_push pulse stores rx_word and sets rx_full for its channel only while serial_run is high, and is dropped otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after rd_en |
| rd_valid | output | 1 | Read data valid |
| fsync | input | 1 | Frame sync from the shift engine |
| rx_push | input | NUM_RX | Per-channel received-word strobe |
| rx_word | input | DATA_W | Received word from the shift engine |
| pin_sel | output | NUM_PINS | Per-pin serial-function select (1 = serial) |
| pin_dir | output | NUM_PINS | Per-pin direction for general-purpose use |
| active | output | 1 | Port out of individual reset |
| serial_run | output | 1 | Serial framing running |
| tx_en | output | NUM_TX | Transmit channel enables |
| rx_en | output | NUM_RX | Receive channel enables |
| irq_en | output | 2 | Interrupt enables |
| cfg_mode | output | PROT_W | Protected configuration field |
| cfg_err | output | 1 | Sticky illegal-configuration-write flag |
| tx_data | output | NUM_TX*DATA_W | Preloaded transmit words, channel 0 lowest |

## Verification
Random pin-select values, half of them all-zero, are interleaved with random control words. This separates the registered OR-of-pins activation from a direction-driven one, and separates locked from unlocked configuration writes, on both sides of every transition. A directed bring-up preloads only one of two enabled transmitters. This shows that underrun is computed per channel from enable and preload at the activation edge. Received-word pushes, reads before and after deactivation, and a held frame sync separate the guarded and unguarded read paths and the frame-aligned start of serial_run from a start at activation. A second hardware reset after the error flag has been set tells the hardware-only clearing of cfg_err apart from clearing on individual reset.

// File: rtl/spir_pkg.sv
package spir_pkg;

   localparam int ADDR_W = 5;

   localparam logic [ADDR_W-1:0] AD_PINSEL = 5'd0;
   localparam logic [ADDR_W-1:0] AD_PINDIR = 5'd1;
   localparam logic [ADDR_W-1:0] AD_CTRL   = 5'd2;
   localparam logic [ADDR_W-1:0] AD_STAT   = 5'd3;
   localparam logic [ADDR_W-1:0] AD_TXMARK = 5'd4;
   localparam logic [1:0]        AD_TXWIN  = 2'b01;   // 8..15
   localparam logic [1:0]        AD_RXWIN  = 2'b10;   // 16..23

   localparam int MAX_CH = 8;

   typedef enum logic [2:0] {
      RS_NONE,
      RS_PINSEL,
      RS_PINDIR,
      RS_CTRL,
      RS_STAT,
      RS_TXMARK,
      RS_TXWORD,
      RS_RXWORD
   } reg_sel_e;

endpackage

// File: rtl/spir_pinmode.sv
module spir_pinmode #(
   parameter int NUM_PINS = 12,
   parameter int DATA_W   = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_sel,
   input  logic                wr_dir,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                fsync,
   output logic [NUM_PINS-1:0] pin_sel,
   output logic [NUM_PINS-1:0] pin_dir,
   output logic                active,
   output logic                act_next,
   output logic                act_rise,
   output logic                act_fall,
   output logic                serial_run
);

   assign act_next = |pin_sel;
   assign act_rise = act_next & ~active;
   assign act_fall = ~act_next & active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_sel    <= '0;
         pin_dir    <= '0;
         active     <= 1'b0;
         serial_run <= 1'b0;
      end else begin
         if (wr_sel) pin_sel <= wdata[NUM_PINS-1:0];
         if (wr_dir) pin_dir <= wdata[NUM_PINS-1:0];
         active <= act_next;
         if (!act_next)
            serial_run <= 1'b0;
         else if (active && fsync)
            serial_run <= 1'b1;
      end
   end

endmodule

// File: rtl/spir_ctrlreg.sv
module spir_ctrlreg #(
   parameter int NUM_TX = 6,
   parameter int NUM_RX = 4,
   parameter int PROT_W = 8,
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              active,
   output logic [NUM_TX-1:0] tx_en,
   output logic [NUM_RX-1:0] rx_en,
   output logic [1:0]        irq_en,
   output logic [PROT_W-1:0] cfg_mode,
   output logic              cfg_err,
   output logic [DATA_W-1:0] ctrl_word
);

   localparam int FREE_W = NUM_TX + NUM_RX + 2;
   localparam int CTRL_W = FREE_W + PROT_W;

   logic [FREE_W-1:0] free_q;
   logic [PROT_W-1:0] prot_q;
   logic [PROT_W-1:0] prot_wr;
   logic              prot_diff;

   assign prot_wr   = wdata[CTRL_W-1:FREE_W];
   assign prot_diff = (prot_wr != prot_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q  <= '0;
         prot_q  <= '0;
         cfg_err <= 1'b0;
      end else if (wr) begin
         free_q <= wdata[FREE_W-1:0];
         if (!active)
            prot_q <= prot_wr;
         else if (prot_diff)
            cfg_err <= 1'b1;
      end
   end

   assign tx_en    = free_q[NUM_TX-1:0];
   assign rx_en    = free_q[NUM_TX +: NUM_RX];
   assign irq_en   = free_q[FREE_W-1 -: 2];
   assign cfg_mode = prot_q;

   always_comb begin
      ctrl_word = '0;
      ctrl_word[CTRL_W-1:0] = {prot_q, free_q};
   end

endmodule

// File: rtl/spir_datapath.sv
module spir_datapath #(
   parameter int NUM_TX = 6,
   parameter int NUM_RX = 4,
   parameter int DATA_W = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_TX-1:0]        wr_tx,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_RX-1:0]        rd_rx,
   input  logic [NUM_RX-1:0]        rx_push,
   input  logic [DATA_W-1:0]        rx_word,
   input  logic                     run,
   input  logic                     act_next,
   input  logic                     act_rise,
   input  logic                     act_fall,
   input  logic [NUM_TX-1:0]        tx_en,
   output logic [NUM_TX*DATA_W-1:0] tx_flat,
   output logic [NUM_RX*DATA_W-1:0] rx_flat,
   output logic [NUM_TX-1:0]        tx_mark,
   output logic [NUM_TX-1:0]        underrun,
   output logic [NUM_RX-1:0]        rx_full
);

   logic [NUM_RX-1:0] take;

   assign take = rx_push & {NUM_RX{run}};

   for (genvar gi = 0; gi < NUM_TX; gi++) begin : g_tx
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          word_q <= '0;
         else if (wr_tx[gi])  word_q <= wdata;
      end
      assign tx_flat[gi*DATA_W +: DATA_W] = word_q;
   end

   for (genvar gr = 0; gr < NUM_RX; gr++) begin : g_rx
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         word_q <= '0;
         else if (take[gr])  word_q <= rx_word;
      end
      assign rx_flat[gr*DATA_W +: DATA_W] = word_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_mark  <= '0;
         underrun <= '0;
         rx_full  <= '0;
      end else begin
         if (act_fall) tx_mark <= '0;
         else          tx_mark <= tx_mark | wr_tx;

         if (!act_next) begin
            underrun <= '0;
            rx_full  <= '0;
         end else if (act_rise) begin
            underrun <= tx_en & ~tx_mark;
            rx_full  <= '0;
         end else begin
            rx_full  <= (rx_full & ~rd_rx) | take;
         end
      end
   end

endmodule

// File: rtl/sp_ireset_ctrl.sv
module sp_ireset_ctrl
   import spir_pkg::*;
#(
   parameter int NUM_PINS = 12,
   parameter int NUM_TX   = 6,
   parameter int NUM_RX   = 4,
   parameter int PROT_W   = 8,
   parameter int DATA_W   = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   output logic                     rd_valid,
   input  logic                     fsync,
   input  logic [NUM_RX-1:0]        rx_push,
   input  logic [DATA_W-1:0]        rx_word,
   output logic [NUM_PINS-1:0]      pin_sel,
   output logic [NUM_PINS-1:0]      pin_dir,
   output logic                     active,
   output logic                     serial_run,
   output logic [NUM_TX-1:0]        tx_en,
   output logic [NUM_RX-1:0]        rx_en,
   output logic [1:0]               irq_en,
   output logic [PROT_W-1:0]        cfg_mode,
   output logic                     cfg_err,
   output logic [NUM_TX*DATA_W-1:0] tx_data
);

   localparam int FREE_W = NUM_TX + NUM_RX + 2;
   localparam int CTRL_W = FREE_W + PROT_W;
   localparam int STAT_W = NUM_RX + NUM_TX + 1;

   if (NUM_TX < 1 || NUM_TX > MAX_CH) begin : g_bad_tx
      $error("NUM_TX out of range");
   end
   if (NUM_RX < 1 || NUM_RX > MAX_CH) begin : g_bad_rx
      $error("NUM_RX out of range");
   end
   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("NUM_PINS must fit the data word");
   end
   if (CTRL_W > DATA_W || STAT_W > DATA_W) begin : g_bad_ctrl
      $error("control or status word wider than DATA_W");
   end

   reg_sel_e          sel;
   logic [2:0]        ch;
   logic              act_next, act_rise, act_fall;
   logic [NUM_TX-1:0] wr_tx;
   logic [NUM_RX-1:0] rd_rx;
   logic [NUM_TX-1:0] tx_mark, underrun;
   logic [NUM_RX-1:0] rx_full;
   logic [NUM_RX*DATA_W-1:0] rx_flat;
   logic [DATA_W-1:0] ctrl_word;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] rd_word;
   logic              rd_ok;
   logic [NUM_TX+NUM_RX-1:0] stat_live;

   assign ch = addr[2:0];

   always_comb begin
      sel = RS_NONE;
      if (addr == AD_PINSEL)      sel = RS_PINSEL;
      else if (addr == AD_PINDIR) sel = RS_PINDIR;
      else if (addr == AD_CTRL)   sel = RS_CTRL;
      else if (addr == AD_STAT)   sel = RS_STAT;
      else if (addr == AD_TXMARK) sel = RS_TXMARK;
      else if (addr[4:3] == AD_TXWIN && 32'(ch) < NUM_TX) sel = RS_TXWORD;
      else if (addr[4:3] == AD_RXWIN && 32'(ch) < NUM_RX) sel = RS_RXWORD;
   end

   always_comb begin
      wr_tx = '0;
      for (int i = 0; i < NUM_TX; i++)
         wr_tx[i] = wr_en && (sel == RS_TXWORD) && (32'(ch) == i);
   end

   spir_pinmode #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_pins (
      .clk(clk), .rst_n(rst_n),
      .wr_sel(wr_en && sel == RS_PINSEL),
      .wr_dir(wr_en && sel == RS_PINDIR),
      .wdata(wdata), .fsync(fsync),
      .pin_sel(pin_sel), .pin_dir(pin_dir),
      .active(active), .act_next(act_next),
      .act_rise(act_rise), .act_fall(act_fall),
      .serial_run(serial_run)
   );

   spir_ctrlreg #(.NUM_TX(NUM_TX), .NUM_RX(NUM_RX), .PROT_W(PROT_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_en && sel == RS_CTRL),
      .wdata(wdata), .active(active),
      .tx_en(tx_en), .rx_en(rx_en), .irq_en(irq_en),
      .cfg_mode(cfg_mode), .cfg_err(cfg_err), .ctrl_word(ctrl_word)
   );

   spir_datapath #(.NUM_TX(NUM_TX), .NUM_RX(NUM_RX), .DATA_W(DATA_W)) u_data (
      .clk(clk), .rst_n(rst_n),
      .wr_tx(wr_tx), .wdata(wdata), .rd_rx(rd_rx),
      .rx_push(rx_push), .rx_word(rx_word), .run(serial_run),
      .act_next(act_next), .act_rise(act_rise), .act_fall(act_fall),
      .tx_en(tx_en), .tx_flat(tx_data), .rx_flat(rx_flat),
      .tx_mark(tx_mark), .underrun(underrun), .rx_full(rx_full)
   );

   assign stat_live = {underrun, rx_full};

   always_comb begin
      stat_word = '0;
      stat_word[NUM_RX-1:0]       = rx_full;
      stat_word[NUM_RX +: NUM_TX] = underrun;
      stat_word[NUM_RX + NUM_TX]  = cfg_err;
   end

   always_comb begin
      rd_word = '0;
      rd_ok   = 1'b1;
      rd_rx   = '0;
      case (sel)
         RS_PINSEL: rd_word[NUM_PINS-1:0] = pin_sel;
         RS_PINDIR: rd_word[NUM_PINS-1:0] = pin_dir;
         RS_CTRL:   rd_word = ctrl_word;
         RS_STAT:   rd_word = stat_word;
         RS_TXMARK: rd_word[NUM_TX-1:0] = tx_mark;
         RS_RXWORD: begin
            if (active) begin
               for (int i = 0; i < NUM_RX; i++) begin
                  if (32'(ch) == i) begin
                     rd_word  = rx_flat[i*DATA_W +: DATA_W];
                     rd_rx[i] = rd_en;
                  end
               end
            end else begin
               rd_ok = 1'b0;
            end
         end
         default: rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else if (rd_en) begin
         rdata    <= rd_ok ? rd_word : '0;
         rd_valid <= rd_ok;
      end else begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/spir_checker.sv
module spir_checker #(
   parameter int NUM_PINS = 12,
   parameter int NUM_TX   = 6,
   parameter int NUM_RX   = 4,
   parameter int PROT_W   = 8,
   parameter int DATA_W   = 24
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_PINS-1:0]      pin_sel,
   input logic                     active,
   input logic                     serial_run,
   input logic                     fsync,
   input logic                     rd_en,
   input logic                     rd_valid,
   input logic [DATA_W-1:0]        rdata,
   input logic [PROT_W-1:0]        cfg_mode,
   input logic                     cfg_err,
   input logic [NUM_TX+NUM_RX-1:0] stat_live
);

   AST_ACTIVE_FROM_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      active == $past(|pin_sel)); // R2

   AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (stat_live == '0 && !serial_run)); // R3

   AST_READ_ONLY_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_en)); // R4

   AST_INVALID_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rdata == '0); // R4

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(active) |-> $stable(cfg_mode)); // R5

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_err) |-> cfg_err); // R6

   AST_RUN_ON_FSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(serial_run) |-> ($past(fsync) && $past(active))); // R7

   AST_RUN_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      serial_run |-> active); // R7

endmodule

bind sp_ireset_ctrl spir_checker #(
   .NUM_PINS(NUM_PINS), .NUM_TX(NUM_TX), .NUM_RX(NUM_RX),
   .PROT_W(PROT_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_sel(pin_sel), .active(active),
   .serial_run(serial_run), .fsync(fsync), .rd_en(rd_en),
   .rd_valid(rd_valid), .rdata(rdata), .cfg_mode(cfg_mode),
   .cfg_err(cfg_err), .stat_live(stat_live)
);

// File: tb/sp_ireset_ctrl_test.sv
module sp_ireset_ctrl_test;

   localparam int NP = 12;
   localparam int NT = 6;
   localparam int NR = 4;
   localparam int PW = 8;
   localparam int DW = 24;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en, rd_en;
   logic [4:0]    addr;
   logic [DW-1:0] wdata, rdata;
   logic          rd_valid, fsync;
   logic [NR-1:0] rx_push;
   logic [DW-1:0] rx_word;
   logic [NP-1:0] pin_sel, pin_dir;
   logic          active, serial_run;
   logic [NT-1:0] tx_en;
   logic [NR-1:0] rx_en;
   logic [1:0]    irq_en;
   logic [PW-1:0] cfg_mode;
   logic          cfg_err;
   logic [NT*DW-1:0] tx_data;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sp_ireset_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .fsync(fsync),
      .rx_push(rx_push), .rx_word(rx_word), .pin_sel(pin_sel), .pin_dir(pin_dir),
      .active(active), .serial_run(serial_run), .tx_en(tx_en), .rx_en(rx_en),
      .irq_en(irq_en), .cfg_mode(cfg_mode), .cfg_err(cfg_err), .tx_data(tx_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [DW-1:0] d, output logic v);
      rd_en = 1'b1; addr = a;
      tick();
      rd_en = 1'b0;
      d = rdata; v = rd_valid;
   endtask

   task automatic hw_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
   endtask

   function automatic logic [19:0] ctrl_model(input logic [19:0] cur, input logic [19:0] wd,
                                              input logic act);
      return {act ? cur[19:12] : wd[19:12], wd[11:0]};
   endfunction

   function automatic logic err_model(input logic err, input logic [19:0] cur,
                                      input logic [19:0] wd, input logic act);
      return err | (act && (wd[19:12] != cur[19:12]));
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      logic          v;
      logic [19:0]   m_ctrl;
      logic          m_err;
      logic          m_act;
      void'($urandom(32'd5511));
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
      fsync = 1'b0; rx_push = '0; rx_word = '0;
      @(negedge clk);
      hw_reset();

      // R1 reset state
      chk("R1 pin_sel", 32'(pin_sel), 0);
      chk("R1 pin_dir", 32'(pin_dir), 0);
      chk("R1 active", 32'(active), 0);
      chk("R1 serial_run", 32'(serial_run), 0);
      chk("R1 cfg_err", 32'(cfg_err), 0);
      bus_read(5'd3, d, v);
      chk("R1 status", {d, v}, {24'h0, 1'b1});
      bus_read(5'd2, d, v);
      chk("R1 ctrl", {d, v}, {24'h0, 1'b1});

      // random phase: R2 activation, R5 lock, R6 error
      m_ctrl = '0; m_err = 1'b0; m_act = 1'b0;
      for (int it = 0; it < 150; it++) begin
         logic [NP-1:0] ps, pd;
         logic [19:0]   cw;
         ps = ($urandom % 2) ? '0 : NP'($urandom);
         pd = NP'($urandom);
         cw = 20'($urandom);
         bus_write(5'd0, 24'(ps));
         chk("R2 no change at write edge", 32'(active), 32'(m_act));
         bus_write(5'd1, 24'(pd));
         m_act = |ps;
         chk("R2 active from pin_sel", 32'(active), 32'(m_act));
         bus_write(5'd2, 24'(cw));
         m_err  = err_model(m_err, m_ctrl, cw, m_act);
         m_ctrl = ctrl_model(m_ctrl, cw, m_act);
         bus_read(5'd2, d, v);
         chk("R5 ctrl readback", 32'(d), 32'(m_ctrl));
         chk("R6 cfg_err model", 32'(cfg_err), 32'(m_err));
         bus_read(5'd1, d, v);
         chk("R2 pin_dir readback", 32'(d), 32'(pd));
      end

      // R6 hardware reset clears the error
      hw_reset();
      chk("R6 cleared by hw reset", 32'(cfg_err), 0);

      // bring-up: program control, preload tx0 only, tx0/tx1 enabled
      bus_write(5'd2, 24'hA5_5_43);  // cfg A5, irq 01, rx 0101, tx 000011
      bus_read(5'd2, d, v);
      chk("R5 ctrl write in reset", 32'(d), 32'h0A5543);
      chk("R5 cfg_mode", 32'(cfg_mode), 32'hA5);
      bus_write(5'd8, 24'h123456);
      bus_read(5'd4, d, v);
      chk("R8 preload mark", 32'(d), 32'h1);
      chk("R8 tx_data ch0", 32'(tx_data[DW-1:0]), 32'h123456);
      bus_write(5'd1, 24'h0F0);
      tick();
      chk("R2 direction does not activate", 32'(active), 0);
      rx_push = 4'b0001; rx_word = 24'h777777;
      tick();
      rx_push = '0;
      bus_write(5'd0, 24'h020);
      chk("R2 still parked at write edge", 32'(active), 0);
      tick();
      chk("R2 active after one edge", 32'(active), 1);
      bus_read(5'd3, d, v);
      chk("R8 underrun ch1 only, R9 no capture in reset", 32'(d), 32'h020);
      tick();
      chk("R7 no run without fsync", 32'(serial_run), 0);
      fsync = 1'b1;
      tick();
      fsync = 1'b0;
      chk("R7 run after fsync", 32'(serial_run), 1);

      rx_push = 4'b0100; rx_word = 24'hABCDEF;
      tick();
      rx_push = '0;
      bus_read(5'd3, d, v);
      chk("R9 rx_full ch2", 32'(d), 32'h024);
      bus_read(5'd18, d, v);
      chk("R4 rx read active", {d, v}, {24'hABCDEF, 1'b1});
      bus_read(5'd3, d, v);
      chk("R4 rx_full cleared by read", 32'(d), 32'h020);

      // protected write while active
      bus_write(5'd2, 24'h3C_9_43);
      bus_read(5'd2, d, v);
      chk("R5 cfg locked, enables updated", 32'(d), 32'h0A5943);
      chk("R6 cfg_err set", 32'(cfg_err), 1);

      // back to individual reset
      bus_write(5'd0, 24'h000);
      tick();
      chk("R3 active low", 32'(active), 0);
      chk("R7 run falls with active", 32'(serial_run), 0);
      bus_read(5'd3, d, v);
      chk("R3 status cleared, R6 err kept", 32'(d), 32'h400);
      bus_read(5'd2, d, v);
      chk("R3 ctrl retained", 32'(d), 32'h0A5943);
      bus_read(5'd18, d, v);
      chk("R4 rx read guarded", {d, v}, {24'h0, 1'b0});
      bus_read(5'd4, d, v);
      chk("R8 marks cleared on reset entry", 32'(d), 0);
      bus_write(5'd2, 24'h3C_9_43);
      chk("R5 cfg writable in reset", 32'(cfg_mode), 32'h3C);
      chk("R6 err stays", 32'(cfg_err), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule